// File: doc/BRIEF.md
# Cache Line Fill Buffer

This block gathers the four 32-bit words that memory returns in a burst after a cache miss. When the miss allocates, the cache sends the line address as a fill request. The block holds that address and records each returned beat in the word slot named by the beat's index. Once all four slots are full, it gives the assembled 128-bit line, with its tag and set, to the cache array in a single one-cycle completion pulse. The array can only write the line, and so mark it valid, at that point.

The cache keeps serving hits while the burst is still arriving. A lookup port compares a word address with the pending line. If the addressed word has already arrived, the lookup returns that word straight from the buffer. Only one fill can be pending at a time; the block holds `req_ready` low to refuse new requests until the current fill has completed.

The controller has three states. `ST_IDLE` waits for a request. `ST_FILL` collects beats. `ST_COMMIT` presents the finished line for one cycle. There are three transitions: **start** (`ST_IDLE` to `ST_FILL`, when a request is accepted), **last beat** (`ST_FILL` to `ST_COMMIT`, when the beat that fills the last empty slot is accepted) and **retire** (`ST_COMMIT` to `ST_IDLE`, always after one cycle).

Top module: `lfb_fill_buffer`

## Requirements
- R1: After reset, `req_ready` is 1 and `done_valid` and `lk_hit` are 0.
- R2: A request is accepted when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is then 0 from the next cycle through the completion cycle, and it returns to 1 in the cycle after the pulse.
- R3: A request raised while `req_ready` is 0 is ignored, and the pending line address does not change.
- R4: Beats may arrive in any order and with idle cycles between them. The word with index i appears at bits [32i+31:32i] of `done_line`.
- R5: `done_valid` is 1 for exactly one cycle, the cycle after the edge that accepts the beat completing the set of four distinct indices. It is never 1 while any index is still missing.
- R6: A repeated beat index overwrites that word and does not count as a new word.
- R7: Beats that arrive while no fill is collecting are ignored. A fill started afterwards begins with no words received.
- R8: `done_tag` is the upper 20 bits of the 28-bit line address, and `done_set` is its lower 8 bits.
- R9: `lk_addr` is {line address, 2-bit word index}. A lookup hits in the same cycle when a fill is pending, the line address matches and that word has arrived. On a hit, `lk_data` is that word.
- R10: A lookup misses when it names a different line, when its word has not arrived, or when no fill is pending. On a miss, `lk_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Fill request strobe |
| req_ready | output | 1 | Block can accept a fill request |
| req_line | input | 28 | Line address of the fill (tag and set) |
| beat_valid | input | 1 | Burst beat present |
| beat_idx | input | 2 | Word index of the beat |
| beat_data | input | 32 | Beat data |
| lk_addr | input | 30 | Lookup word address {line, word index} |
| lk_hit | output | 1 | Lookup word is held in the buffer |
| lk_data | output | 32 | Word returned on a hit, 0 otherwise |
| done_valid | output | 1 | One-cycle completion pulse |
| done_tag | output | 20 | Tag of the completed line |
| done_set | output | 8 | Set index of the completed line |
| done_line | output | 128 | Assembled line, word i at bits [32i+31:32i] |

## Verification
The assertions assume three things about the environment. It raises a new request only while `req_ready` is 1 if it expects that request to take effect. Its beat indices stay within 0 to 3. Reset is applied before the first request. The stimulus drives every input one time unit after a rising edge and samples outputs between edges. It raises `req_valid` against a busy block only on purpose, to check that the request is refused. It sends stray or repeated beats only to check that they are ignored or overwrite a word, and then always completes the burst, so that every fill it starts ends in a completion pulse.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_COMMIT = 2'd2
    } lfb_state_e;

endpackage

// File: rtl/lfb_mask.sv
module lfb_mask #(
    parameter int BEATS = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             set_en,
    input  logic [IDX_W-1:0] set_idx,
    output logic [BEATS-1:0] mask_q,
    output logic             full_next
);

    logic [BEATS-1:0] set_vec;

    always_comb begin
        set_vec = '0;
        if (set_en) begin
            set_vec[set_idx] = 1'b1;
        end
        full_next = &(mask_q | set_vec);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_q | set_vec;
        end
    end

endmodule

// File: rtl/lfb_words.sv
module lfb_words #(
    parameter int WORD_W = 32,
    parameter int BEATS  = 4,
    parameter int IDX_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_data,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [WORD_W-1:0]       rd_data,
    output logic [WORD_W*BEATS-1:0] line
);

    logic [WORD_W-1:0] slot_q [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
        assign line[g*WORD_W +: WORD_W] = slot_q[g];
    end

    assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/lfb_fill_buffer.sv
module lfb_fill_buffer
    import lfb_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int BEATS       = 4,
    parameter int LINE_ADDR_W = 28,
    parameter int SET_W       = 8,
    localparam int IDX_W      = $clog2(BEATS),
    localparam int TAG_W      = LINE_ADDR_W - SET_W,
    localparam int LINE_W     = WORD_W * BEATS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic [LINE_ADDR_W-1:0]     req_line,
    input  logic                       beat_valid,
    input  logic [IDX_W-1:0]           beat_idx,
    input  logic [WORD_W-1:0]          beat_data,
    input  logic [LINE_ADDR_W+IDX_W-1:0] lk_addr,
    output logic                       lk_hit,
    output logic [WORD_W-1:0]          lk_data,
    output logic                       done_valid,
    output logic [TAG_W-1:0]           done_tag,
    output logic [SET_W-1:0]           done_set,
    output logic [LINE_W-1:0]          done_line
);

    lfb_state_e             state_q, state_d;
    logic [LINE_ADDR_W-1:0] line_q;
    logic [BEATS-1:0]       mask_q;
    logic                   full_next;
    logic                   start;
    logic                   beat_take;
    logic [WORD_W-1:0]      rd_word;
    logic [IDX_W-1:0]       lk_idx;
    logic [LINE_ADDR_W-1:0] lk_line;

    assign lk_idx  = lk_addr[IDX_W-1:0];
    assign lk_line = lk_addr[LINE_ADDR_W+IDX_W-1:IDX_W];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_FILL;
            ST_FILL:   if (beat_valid && full_next) state_d = ST_COMMIT;
            ST_COMMIT: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready  = 1'b0;
        done_valid = 1'b0;
        beat_take  = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready  = 1'b1;
            ST_FILL:   beat_take  = beat_valid;
            ST_COMMIT: done_valid = 1'b1;
            default:   req_ready  = 1'b0;
        endcase
        start = req_ready && req_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '0;
        end else if (start) begin
            line_q <= req_line;
        end
    end

    lfb_mask #(
        .BEATS (BEATS),
        .IDX_W (IDX_W)
    ) mask_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start),
        .set_en    (beat_take),
        .set_idx   (beat_idx),
        .mask_q    (mask_q),
        .full_next (full_next)
    );

    lfb_words #(
        .WORD_W (WORD_W),
        .BEATS  (BEATS),
        .IDX_W  (IDX_W)
    ) words_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (beat_take),
        .wr_idx  (beat_idx),
        .wr_data (beat_data),
        .rd_idx  (lk_idx),
        .rd_data (rd_word),
        .line    (done_line)
    );

    // Lookup against the pending line
    always_comb begin
        lk_hit  = (state_q != ST_IDLE) && (lk_line == line_q) && mask_q[lk_idx];
        lk_data = lk_hit ? rd_word : '0;
    end

    assign done_tag = line_q[LINE_ADDR_W-1:SET_W];
    assign done_set = line_q[SET_W-1:0];

endmodule

// File: rtl/lfb_fill_buffer_chk.sv
module lfb_fill_buffer_chk #(
    parameter int BEATS  = 4,
    parameter int WORD_W = 32,
    parameter int TAG_W  = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              done_valid,
    input logic [TAG_W-1:0]  done_tag,
    input logic              lk_hit,
    input logic [WORD_W-1:0] lk_data,
    input logic [BEATS-1:0]  fill_mask
);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    // R5
    done_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (&fill_mask));

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R2
    ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> req_ready);

    // R3
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready)) |-> $stable(done_tag));

    // R10
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_data == '0));

    // R10
    idle_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !lk_hit);

endmodule

bind lfb_fill_buffer lfb_fill_buffer_chk #(
    .BEATS  (BEATS),
    .WORD_W (WORD_W),
    .TAG_W  (TAG_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .done_tag   (done_tag),
    .lk_hit     (lk_hit),
    .lk_data    (lk_data),
    .fill_mask  (mask_q)
);

// File: tb/lfb_fill_buffer_tb_top.sv
module lfb_fill_buffer_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 4;
    // vector: {line address[27:0], order[7:0]}; beat k carries index order[2k+1:2k]
    localparam logic [35:0] VECS [NVEC] = '{
        {28'h0000000, 8'hE4},
        {28'hFFFFFFF, 8'h1B},
        {28'h12345A7, 8'h72},
        {28'hABCDE3C, 8'h8D}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [27:0]  req_line = '0;
    logic         beat_valid = 1'b0;
    logic [1:0]   beat_idx = '0;
    logic [31:0]  beat_data = '0;
    logic [29:0]  lk_addr = '0;
    logic         lk_hit;
    logic [31:0]  lk_data;
    logic         done_valid;
    logic [19:0]  done_tag;
    logic [7:0]   done_set;
    logic [127:0] done_line;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lfb_fill_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .beat_valid(beat_valid), .beat_idx(beat_idx), .beat_data(beat_data),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data),
        .done_valid(done_valid), .done_tag(done_tag), .done_set(done_set),
        .done_line(done_line)
    );

    function automatic logic [31:0] wd(input logic [27:0] ln, input int i);
        return {ln, 4'(i) << 2} ^ (32'hC3C3_0F0F + 32'(i) * 32'h0101_1111);
    endfunction

    task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_req(input logic [27:0] ln);
        req_valid = 1'b1;
        req_line  = ln;
        step();
        req_valid = 1'b0;
    endtask

    task automatic do_beat(input logic [1:0] ix, input logic [31:0] d);
        beat_valid = 1'b1;
        beat_idx   = ix;
        beat_data  = d;
        step();
        beat_valid = 1'b0;
    endtask

    task automatic look(input logic [27:0] ln, input logic [1:0] ix, input bit hit, input logic [31:0] d, input string rq);
        lk_addr = {ln, ix};
        #1;
        chk(lk_hit == hit, rq, 128'(lk_hit), 128'(hit));
        chk(lk_data == (hit ? d : 32'h0), rq, 128'(lk_data), 128'(hit ? d : 32'h0));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [127:0] exp_line;
        logic [27:0]  ln;

        // R1 reset state
        #3;
        chk(req_ready == 1'b1, "R1 ready", 128'(req_ready), 128'(1));
        chk(done_valid == 1'b0, "R1 done", 128'(done_valid), 128'(0));
        chk(lk_hit == 1'b0, "R1 hit", 128'(lk_hit), 128'(0));
        step();
        rst_n = 1'b1;
        step();

        // table walk: R4 R5 R8 R9 R10
        for (int v = 0; v < NVEC; v++) begin
            ln = VECS[v][35:8];
            exp_line = '0;
            for (int i = 0; i < 4; i++) exp_line[32*i +: 32] = wd(ln, i);
            look(ln, 2'd0, 1'b0, 32'h0, "R10 idle miss");
            do_req(ln);
            chk(req_ready == 1'b0, "R2 ready low", 128'(req_ready), 128'(0));
            for (int k = 0; k < 4; k++) begin
                logic [1:0] ix;
                ix = VECS[v][2*k +: 2];
                if (k == 2) begin
                    logic [1:0] f;
                    f = VECS[v][1:0];
                    look(ln, f, 1'b1, wd(ln, int'(f)), "R9 hit");
                    look(ln ^ 28'h0000100, f, 1'b0, 32'h0, "R10 other line");
                    look(ln, VECS[v][7:6], 1'b0, 32'h0, "R10 not received");
                end
                chk(done_valid == 1'b0, "R5 early", 128'(done_valid), 128'(0));
                do_beat(ix, wd(ln, int'(ix)));
            end
            chk(done_valid == 1'b1, "R5 pulse", 128'(done_valid), 128'(1));
            chk(done_line == exp_line, "R4 line", done_line, exp_line);
            chk(done_tag == ln[27:8], "R8 tag", 128'(done_tag), 128'(ln[27:8]));
            chk(done_set == ln[7:0], "R8 set", 128'(done_set), 128'(ln[7:0]));
            chk(req_ready == 1'b0, "R2 busy at commit", 128'(req_ready), 128'(0));
            step();
            chk(done_valid == 1'b0, "R5 one cycle", 128'(done_valid), 128'(0));
            chk(req_ready == 1'b1, "R2 ready back", 128'(req_ready), 128'(1));
        end

        // R7 stray beats while idle, R6 duplicate index, R4 gaps
        ln = 28'h5555AAA;
        do_beat(2'd1, 32'hDEAD_BEEF);
        do_beat(2'd2, 32'hDEAD_BEEF);
        do_req(ln);
        look(ln, 2'd1, 1'b0, 32'h0, "R7 stray beat ignored");
        do_beat(2'd0, 32'h1111_1111);
        step();
        do_beat(2'd0, 32'h2222_2222);
        chk(done_valid == 1'b0, "R6 duplicate no count", 128'(done_valid), 128'(0));
        look(ln, 2'd0, 1'b1, 32'h2222_2222, "R6 overwrite");
        do_beat(2'd1, 32'h3333_3333);
        step();
        step();
        do_beat(2'd2, 32'h4444_4444);
        chk(done_valid == 1'b0, "R5 three words", 128'(done_valid), 128'(0));
        // R3 request while busy
        req_valid = 1'b1;
        req_line  = 28'h0F0F0F0;
        #1;
        chk(req_ready == 1'b0, "R3 busy ready", 128'(req_ready), 128'(0));
        step();
        req_valid = 1'b0;
        do_beat(2'd3, 32'h5555_5555);
        exp_line = {32'h5555_5555, 32'h4444_4444, 32'h3333_3333, 32'h2222_2222};
        chk(done_valid == 1'b1, "R5 pulse after gaps", 128'(done_valid), 128'(1));
        chk(done_line == exp_line, "R6 line", done_line, exp_line);
        chk(done_tag == ln[27:8], "R3 tag kept", 128'(done_tag), 128'(ln[27:8]));
        chk(done_set == ln[7:0], "R3 set kept", 128'(done_set), 128'(ln[7:0]));
        step();
        look(ln, 2'd3, 1'b0, 32'h0, "R10 after retire");

        // R1 reset mid-fill
        do_req(28'h0000123);
        do_beat(2'd0, 32'h7);
        rst_n = 1'b0;
        #1;
        chk(req_ready == 1'b1, "R1 reset mid fill", 128'(req_ready), 128'(1));
        chk(lk_hit == 1'b0, "R1 reset hit", 128'(lk_hit), 128'(0));

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule